// File: doc/BRIEF.md
# Descriptor Ring Status Engine

This block keeps a table of eight-byte buffer descriptors that a host programs over a small register bus. The leading part of the table forms a transmit ring and the rest forms a receive ring. A programmable transmit count sets where the split falls. Each descriptor holds a status/length word and a buffer address word. A status bit marks the entry as owned by the hardware. A per-entry wrap bit sends the ring pointer back to the first entry of its ring.

The engine walks the transmit ring in order. Each ready entry is offered to a stub transmitter. When the transmitter reports completion, the engine writes back the completion status and releases the entry. Incoming frames from a stub receiver are stored into the next empty receive entry. The engine writes back the frame length and error bits and hands the buffer address to the receiver. Completions can set interrupt source bits. Each source bit is cleared by writing a one to it, and the interrupt output is the OR of the source bits that are also set in a mask register.

Top module: `bd_ring_engine`

## Requirements
- R1: Descriptor i is at byte address 0x400 + 8*i. The status word is at offset 0 and the buffer address at offset 4. A host read returns the stored word one clock after the address is presented.
- R2: The register map is: 0x00 control (bit 0 receive enable, bit 1 transmit enable), 0x04 interrupt source, 0x08 interrupt mask, 0x0C transmit count (reset value NUM_BD/2). A count written above NUM_BD reads back as NUM_BD. The receive ring starts at table index equal to the count.
- R3: When transmit is enabled and the current transmit entry has status bit 15 (ready) set, the engine raises tx_valid. It presents the length from bits 31:16, the buffer address, pad from bit 12 and CRC enable from bit 11. It holds all of these unchanged until tx_done.
- R4: On tx_done the entry's status word is rewritten. Bit 15 is cleared and bits 8:0 are replaced by tx_status (bit 0 carrier lost, 1 defer, 2 late collision, 3 retry limit, 7:4 retry count, 8 underrun). Bits 31:16 and 14:9 are kept.
- R5: A transmit entry with bit 15 clear is not offered. The engine polls it again until the host sets the bit, and then offers it.
- R6: After an entry completes, its ring moves to the next index. If the entry's bit 13 (wrap) is set, the ring returns to its first entry instead: index 0 for transmit, index equal to the count for receive.
- R7: A frame arriving while the current receive entry has bit 15 (empty) set is written back as follows: length in bits 31:16, bit 15 cleared, bits 14:9 kept, and bits 8:0 from rx_err (0 late collision, 1 CRC, 2 short, 3 too long, 4 dribble, 5 invalid symbol, 6 overrun, 7 miss, 8 control). rx_store pulses for one cycle with the entry's buffer address.
- R8: A frame arriving while the current receive entry is not empty is dropped. In that case the table and the receive pointer are unchanged and source bit 4 (busy) is set.
- R9: Source bits are 0 TX frame, 1 TX error, 2 RX frame, 3 RX error, 4 busy, 5 TX control and 6 RX control. They are set only when the completed entry has bit 14 set, except for busy and TX control.
  - A transmit completion sets bit 1 if any of tx_status bits 0, 2, 3 or 8 is set, and bit 0 otherwise.
  - A receive completion sets bit 3 if any of rx_err bits 7:0 is set, otherwise bit 6 if bit 8 is set, and otherwise bit 2.
  - A tx_ctrl_sent pulse sets bit 5.
- R10: Writing 1 to a source bit clears it, and a new event in the same cycle wins over the clear. The irq output equals the OR of (source AND mask), registered one cycle behind the source.
- R11: While a ring's enable bit is clear, its pointer is held at the ring's first entry, and a disabled receiver ignores incoming frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 11 | Host byte address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle latency |
| tx_valid | output | 1 | Transmit entry offered |
| tx_len | output | 16 | Transmit frame length |
| tx_buf_addr | output | 32 | Transmit buffer address |
| tx_pad | output | 1 | Pad request of the entry |
| tx_crc | output | 1 | CRC append request of the entry |
| tx_done | input | 1 | Transmitter finished the offered entry |
| tx_status | input | 9 | Transmit completion status |
| tx_ctrl_sent | input | 1 | Transmitter sent a control frame |
| rx_valid | input | 1 | Frame arrived (one-cycle pulse) |
| rx_len | input | 16 | Received length including CRC |
| rx_err | input | 9 | Receive error and control flags |
| rx_store | output | 1 | Frame accepted into an entry |
| rx_buf_addr | output | 32 | Buffer address of the accepting entry |
| irq | output | 1 | Interrupt request |

## Verification
The transmit ring is tried with three entries in turn:
- a clean completion with a retry count, which separates status replacement from corruption of the length and control bits;
- an underrun/late-collision completion on a wrap entry, which separates the error source from the frame source;
- a re-armed entry without interrupt enable, which shows that wrap returns to index 0 and that no source bit is set.

Receive frames are sent in the following order:
- a clean frame;
- a CRC error frame;
- a frame that hits a non-empty entry;
- a control frame;
- a frame while the receiver is disabled.

This order tells apart the three receive source bits, busy dropping, receive wrap back to the count, and the pointer reset on disable. Mask and clear writes are interleaved to show that irq follows only masked sources.

// File: rtl/bd_ring_pkg.sv
package bd_ring_pkg;
  localparam int OWN_B  = 15;
  localparam int IE_B   = 14;
  localparam int WRAP_B = 13;
  localparam int PAD_B  = 12;
  localparam int CRC_B  = 11;

  localparam int IRQ_W    = 7;
  localparam int IRQ_TXF  = 0;
  localparam int IRQ_TXE  = 1;
  localparam int IRQ_RXF  = 2;
  localparam int IRQ_RXE  = 3;
  localparam int IRQ_BUSY = 4;
  localparam int IRQ_TXC  = 5;
  localparam int IRQ_RXC  = 6;

  localparam logic [8:0] TX_ERR_MASK = 9'h10D;

  typedef enum logic [1:0] {ST_IDLE, ST_TX_CHK, ST_TX_WAIT, ST_RX_CHK} walk_state_t;
endpackage

// File: rtl/bd_ring_table.sv
module bd_ring_table #(
  parameter int NUM_BD = 128,
  localparam int IDX_W = $clog2(NUM_BD)
) (
  input  logic             clk,
  input  logic             h_we,
  input  logic             h_word,
  input  logic [IDX_W-1:0] h_idx,
  input  logic [31:0]      h_wdata,
  output logic [31:0]      h_rdata,
  input  logic             e_we,
  input  logic [IDX_W-1:0] e_wr_idx,
  input  logic [31:0]      e_wdata,
  input  logic [IDX_W-1:0] e_rd_idx,
  output logic [31:0]      e_stat,
  output logic [31:0]      e_addr
);
  logic [31:0] stat_mem [NUM_BD];
  logic [31:0] addr_mem [NUM_BD];

  // Status words: host port and engine port; the engine write-back wins a tie.
  always_ff @(posedge clk) begin
    if (h_we && !h_word) stat_mem[h_idx] <= h_wdata;
    if (e_we) stat_mem[e_wr_idx] <= e_wdata;
    e_stat <= stat_mem[e_rd_idx];
  end

  always_ff @(posedge clk) begin
    if (h_we && h_word) addr_mem[h_idx] <= h_wdata;
    e_addr <= addr_mem[e_rd_idx];
  end

  always_ff @(posedge clk) begin
    h_rdata <= h_word ? addr_mem[h_idx] : stat_mem[h_idx];
  end
endmodule

// File: rtl/bd_ring_walker.sv
module bd_ring_walker
  import bd_ring_pkg::*;
#(
  parameter int NUM_BD = 128,
  localparam int IDX_W = $clog2(NUM_BD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic [IDX_W:0]   tx_count,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [31:0]      e_stat,
  input  logic [31:0]      e_addr,
  output logic             we,
  output logic [IDX_W-1:0] wr_idx,
  output logic [31:0]      wdata,
  output logic             tx_valid,
  output logic [15:0]      tx_len,
  output logic [31:0]      tx_addr,
  output logic             tx_pad,
  output logic             tx_crc,
  input  logic             tx_done,
  input  logic [8:0]       tx_status,
  input  logic             rx_valid,
  input  logic [15:0]      rx_len,
  input  logic [8:0]       rx_err,
  output logic             rx_store,
  output logic [31:0]      rx_addr,
  output logic [IRQ_W-1:0] irq_set
);
  walk_state_t st;
  logic [IDX_W-1:0] tx_ptr, rx_ptr, cur_idx;
  logic [31:0]      cur_stat;
  logic             hold_v;
  logic [15:0]      hold_len;
  logic [8:0]       hold_err;
  logic [IDX_W:0]   rx_sum;
  logic             rx_none, rx_ok, drop_new;

  assign rx_sum   = tx_count + {1'b0, rx_ptr};
  assign rx_none  = rx_sum >= (IDX_W+1)'(NUM_BD);
  assign rx_ok    = e_stat[OWN_B] && !rx_none;
  assign rd_idx   = hold_v ? rx_sum[IDX_W-1:0] : tx_ptr;
  assign drop_new = rx_valid && rx_en && hold_v && (st != ST_RX_CHK);

  always_comb begin
    we      = 1'b0;
    wr_idx  = cur_idx;
    wdata   = cur_stat;
    irq_set = '0;
    if (st == ST_TX_WAIT && tx_done) begin
      we    = 1'b1;
      wdata = {cur_stat[31:16], 1'b0, cur_stat[14:9], tx_status};
      if (cur_stat[IE_B]) begin
        if (|(tx_status & TX_ERR_MASK)) irq_set[IRQ_TXE] = 1'b1;
        else                            irq_set[IRQ_TXF] = 1'b1;
      end
    end
    if (st == ST_RX_CHK) begin
      if (rx_ok) begin
        we    = 1'b1;
        wdata = {hold_len, 1'b0, e_stat[14:9], hold_err};
        if (e_stat[IE_B]) begin
          if (|hold_err[7:0])   irq_set[IRQ_RXE] = 1'b1;
          else if (hold_err[8]) irq_set[IRQ_RXC] = 1'b1;
          else                  irq_set[IRQ_RXF] = 1'b1;
        end
      end else begin
        irq_set[IRQ_BUSY] = 1'b1;
      end
    end
    if (drop_new) irq_set[IRQ_BUSY] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      tx_ptr   <= '0;
      rx_ptr   <= '0;
      cur_idx  <= '0;
      cur_stat <= '0;
      hold_v   <= 1'b0;
      hold_len <= '0;
      hold_err <= '0;
      tx_valid <= 1'b0;
      tx_len   <= '0;
      tx_addr  <= '0;
      tx_pad   <= 1'b0;
      tx_crc   <= 1'b0;
      rx_store <= 1'b0;
      rx_addr  <= '0;
    end else begin
      rx_store <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (hold_v) begin
            cur_idx <= rx_sum[IDX_W-1:0];
            st      <= ST_RX_CHK;
          end else if (tx_en && tx_count != '0) begin
            cur_idx <= tx_ptr;
            st      <= ST_TX_CHK;
          end
        end
        ST_TX_CHK: begin
          if (tx_en && e_stat[OWN_B]) begin
            tx_valid <= 1'b1;
            tx_len   <= e_stat[31:16];
            tx_addr  <= e_addr;
            tx_pad   <= e_stat[PAD_B];
            tx_crc   <= e_stat[CRC_B];
            cur_stat <= e_stat;
            st       <= ST_TX_WAIT;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_TX_WAIT: begin
          if (tx_done) begin
            tx_valid <= 1'b0;
            st       <= ST_IDLE;
            tx_ptr   <= cur_stat[WRAP_B] ? '0 : tx_ptr + 1'b1;
          end
        end
        ST_RX_CHK: begin
          st <= ST_IDLE;
          if (rx_ok) begin
            rx_store <= 1'b1;
            rx_addr  <= e_addr;
            rx_ptr   <= (e_stat[WRAP_B] || rx_sum >= (IDX_W+1)'(NUM_BD-1)) ? '0 : rx_ptr + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (st == ST_RX_CHK) hold_v <= 1'b0;
      if (rx_valid && rx_en && (!hold_v || st == ST_RX_CHK)) begin
        hold_v   <= 1'b1;
        hold_len <= rx_len;
        hold_err <= rx_err;
      end
      if (!rx_en) begin
        hold_v <= 1'b0;
        rx_ptr <= '0;
      end
      if (!tx_en) tx_ptr <= '0;
    end
  end

  AST_TX_OFFER_HELD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_done) |=> (tx_valid && $stable(tx_len) && $stable(tx_addr))); // R3
  AST_STORE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_store |=> !rx_store); // R7
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RX_CHK && !rx_ok) |-> (!we && !$rose(rx_store))); // R8
  AST_TX_PTR_HOME: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (tx_ptr == '0)); // R11
  AST_RX_PTR_HOME: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (rx_ptr == '0 && !hold_v)); // R11
endmodule

// File: rtl/bd_ring_irq.sv
module bd_ring_irq
  import bd_ring_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_W-1:0] set,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_in,
  output logic [IRQ_W-1:0] src,
  output logic [IRQ_W-1:0] mask,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      src  <= '0;
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      src <= (src & ~(clr_we ? clr_bits : '0)) | set;
      if (mask_we) mask <= mask_in;
      irq <= |(src & mask);
    end
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((src & $past(clr_bits & ~set)) == '0)); // R10
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
    (set != '0) |=> ((src & $past(set)) == $past(set))); // R10
endmodule

// File: rtl/bd_ring_engine.sv
module bd_ring_engine
  import bd_ring_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int AW     = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [10:0] host_addr,
  input  logic        host_we,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        tx_valid,
  output logic [15:0] tx_len,
  output logic [31:0] tx_buf_addr,
  output logic        tx_pad,
  output logic        tx_crc,
  input  logic        tx_done,
  input  logic [8:0]  tx_status,
  input  logic        tx_ctrl_sent,
  input  logic        rx_valid,
  input  logic [15:0] rx_len,
  input  logic [8:0]  rx_err,
  output logic        rx_store,
  output logic [31:0] rx_buf_addr,
  output logic        irq
);
  localparam int IDX_W = $clog2(NUM_BD);

  logic [1:0]       ctrl_q;
  logic [IDX_W:0]   tx_count_q;
  logic             is_mem, rd_mem_q;
  logic [31:0]      reg_rdata_q, mem_rdata;
  logic [IDX_W-1:0] e_rd_idx, e_wr_idx;
  logic             e_we;
  logic [31:0]      e_wdata, e_stat, e_addr;
  logic [IRQ_W-1:0] walk_set, all_set, src, mask;
  logic             reg_we;

  assign is_mem = host_addr[AW-1];
  assign reg_we = host_we && !is_mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= '0;
      tx_count_q  <= (IDX_W+1)'(NUM_BD / 2);
      rd_mem_q    <= 1'b0;
      reg_rdata_q <= '0;
    end else begin
      if (reg_we && host_addr[3:2] == 2'd0) ctrl_q <= host_wdata[1:0];
      if (reg_we && host_addr[3:2] == 2'd3)
        tx_count_q <= (host_wdata > 32'(NUM_BD)) ? (IDX_W+1)'(NUM_BD) : host_wdata[IDX_W:0];
      rd_mem_q <= is_mem;
      case (host_addr[3:2])
        2'd0:    reg_rdata_q <= {30'd0, ctrl_q};
        2'd1:    reg_rdata_q <= {{(32-IRQ_W){1'b0}}, src};
        2'd2:    reg_rdata_q <= {{(32-IRQ_W){1'b0}}, mask};
        default: reg_rdata_q <= {{(31-IDX_W){1'b0}}, tx_count_q};
      endcase
    end
  end

  assign host_rdata = rd_mem_q ? mem_rdata : reg_rdata_q;

  bd_ring_table #(.NUM_BD(NUM_BD)) u_table (
    .clk(clk),
    .h_we(host_we && is_mem),
    .h_word(host_addr[2]),
    .h_idx(host_addr[3 +: IDX_W]),
    .h_wdata(host_wdata),
    .h_rdata(mem_rdata),
    .e_we(e_we),
    .e_wr_idx(e_wr_idx),
    .e_wdata(e_wdata),
    .e_rd_idx(e_rd_idx),
    .e_stat(e_stat),
    .e_addr(e_addr)
  );

  bd_ring_walker #(.NUM_BD(NUM_BD)) u_walker (
    .clk(clk), .rst(rst),
    .tx_en(ctrl_q[1]), .rx_en(ctrl_q[0]), .tx_count(tx_count_q),
    .rd_idx(e_rd_idx), .e_stat(e_stat), .e_addr(e_addr),
    .we(e_we), .wr_idx(e_wr_idx), .wdata(e_wdata),
    .tx_valid(tx_valid), .tx_len(tx_len), .tx_addr(tx_buf_addr),
    .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .tx_status(tx_status),
    .rx_valid(rx_valid), .rx_len(rx_len), .rx_err(rx_err),
    .rx_store(rx_store), .rx_addr(rx_buf_addr),
    .irq_set(walk_set)
  );

  always_comb begin
    all_set = walk_set;
    if (tx_ctrl_sent) all_set[IRQ_TXC] = 1'b1;
  end

  bd_ring_irq u_irq (
    .clk(clk), .rst(rst),
    .set(all_set),
    .clr_we(reg_we && host_addr[3:2] == 2'd1),
    .clr_bits(host_wdata[IRQ_W-1:0]),
    .mask_we(reg_we && host_addr[3:2] == 2'd2),
    .mask_in(host_wdata[IRQ_W-1:0]),
    .src(src), .mask(mask), .irq(irq)
  );

  AST_COUNT_CLAMP: assert property (@(posedge clk) disable iff (rst)
    tx_count_q <= (IDX_W+1)'(NUM_BD)); // R2
endmodule

// File: tb/bd_ring_engine_tb.sv
module bd_ring_engine_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [10:0] host_addr = '0;
  logic host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic tx_valid, tx_pad, tx_crc, rx_store, irq;
  logic [15:0] tx_len;
  logic [31:0] tx_buf_addr, rx_buf_addr;
  logic tx_done = 1'b0, tx_ctrl_sent = 1'b0, rx_valid = 1'b0;
  logic [8:0] tx_status = '0, rx_err = '0;
  logic [15:0] rx_len = '0;

  int checks = 0, errors = 0, cycles = 0, store_cnt = 0;
  logic [31:0] store_addr = '0;
  logic [31:0] m_stat [8];
  logic [6:0] m_src = '0;

  always #10 clk = ~clk;

  bd_ring_engine u_dut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_valid(tx_valid), .tx_len(tx_len), .tx_buf_addr(tx_buf_addr),
    .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .tx_status(tx_status),
    .tx_ctrl_sent(tx_ctrl_sent), .rx_valid(rx_valid), .rx_len(rx_len),
    .rx_err(rx_err), .rx_store(rx_store), .rx_buf_addr(rx_buf_addr), .irq(irq)
  );

  always @(negedge clk) if (rx_store) begin
    store_cnt++;
    store_addr = rx_buf_addr;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [10:0] a, logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic set_bd(int i, logic [31:0] s, logic [31:0] adr);
    m_stat[i] = s;
    wr(11'(32'h400 + i*8), s);
    wr(11'(32'h404 + i*8), adr);
  endtask

  task automatic chk_bd(string req, int i);
    logic [31:0] d;
    rd(11'(32'h400 + i*8), d);
    chk(req, d, m_stat[i]);
  endtask

  task automatic chk_src(string req);
    logic [31:0] d;
    rd(11'h004, d);
    chk(req, d, {25'd0, m_src});
  endtask

  task automatic clr_src();
    wr(11'h004, 32'h7F);
    m_src = '0;
  endtask

  task automatic wait_tx(string req);
    int n = 0;
    while (!tx_valid && n < 60) begin @(negedge clk); n++; end
    chk(req, {31'd0, tx_valid}, 32'd1);
  endtask

  task automatic finish_tx(logic [8:0] s);
    @(negedge clk); tx_done = 1'b1; tx_status = s;
    @(negedge clk); tx_done = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame(logic [15:0] l, logic [8:0] e);
    @(negedge clk); rx_valid = 1'b1; rx_len = l; rx_err = e;
    @(negedge clk); rx_valid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    int sc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Reset state
    chk("R10 irq after reset", {31'd0, irq}, 0);
    chk("R3 tx_valid after reset", {31'd0, tx_valid}, 0);
    rd(11'h000, d); chk("R2 control reset", d, 0);
    rd(11'h00C, d); chk("R2 count reset", d, 64);
    chk_src("R9 sources reset");
    // Clamp
    wr(11'h00C, 200); rd(11'h00C, d); chk("R2 count clamp", d, 128);
    wr(11'h00C, 4);   rd(11'h00C, d); chk("R2 count write", d, 4);
    // Transmit ring
    set_bd(0, 32'h0064C800, 32'h1000);
    set_bd(1, 32'h0028F000, 32'h2000);
    rd(11'h404, d); chk("R1 address word", d, 32'h1000);
    chk_bd("R1 status word", 1);
    wr(11'h000, 2);
    wait_tx("R3 offer entry 0");
    chk("R3 length", {16'd0, tx_len}, 100);
    chk("R3 address", tx_buf_addr, 32'h1000);
    chk("R3 pad/crc", {30'd0, tx_pad, tx_crc}, 1);
    repeat (3) @(negedge clk);
    chk("R3 held", {15'd0, tx_valid, tx_len}, {15'd0, 1'b1, 16'd100});
    finish_tx(9'h020);
    m_stat[0] = 32'h00644820; m_src[0] = 1'b1;
    chk_bd("R4 write-back entry 0", 0);
    chk_src("R9 TX frame source");
    chk("R10 irq masked off", {31'd0, irq}, 0);
    wait_tx("R6 next entry offered");
    chk("R6 entry 1 address", tx_buf_addr, 32'h2000);
    chk("R3 entry 1 pad", {31'd0, tx_pad}, 1);
    finish_tx(9'h104);
    m_stat[1] = 32'h00287104; m_src[1] = 1'b1;
    chk_bd("R4 write-back entry 1", 1);
    chk_src("R9 TX error source");
    repeat (10) @(negedge clk);
    chk("R5 stall on not-ready", {31'd0, tx_valid}, 0);
    set_bd(0, 32'h003C8000, 32'h1000);
    wait_tx("R5 offer after ready");
    chk("R6 wrap to index 0", tx_buf_addr, 32'h1000);
    chk("R3 length 60", {16'd0, tx_len}, 60);
    finish_tx(9'h008);
    m_stat[0] = 32'h003C0008;
    chk_bd("R4 write-back no IE", 0);
    chk_src("R9 no source without IE");
    // Mask and clear
    wr(11'h008, 32'h1); repeat (2) @(negedge clk);
    chk("R10 irq on masked source", {31'd0, irq}, 1);
    wr(11'h004, 32'h1); m_src[0] = 1'b0; repeat (2) @(negedge clk);
    chk_src("R10 write-one clears");
    chk("R10 irq low after clear", {31'd0, irq}, 0);
    wr(11'h008, 32'h7F); clr_src(); repeat (2) @(negedge clk);
    chk("R10 irq low all clear", {31'd0, irq}, 0);
    // Receive ring
    set_bd(4, 32'h0000C000, 32'h3000);
    set_bd(5, 32'h0000E000, 32'h4000);
    wr(11'h000, 3);
    sc = store_cnt;
    frame(64, 9'h000);
    m_stat[4] = 32'h00404000; m_src[2] = 1'b1;
    chk("R7 store pulse", store_cnt, sc + 1);
    chk("R7 store address", store_addr, 32'h3000);
    chk_bd("R7 write-back entry 4", 4);
    chk_src("R9 RX frame source");
    clr_src();
    frame(70, 9'h002);
    m_stat[5] = 32'h00466002; m_src[3] = 1'b1;
    chk("R2 RX ring second entry", store_addr, 32'h4000);
    chk_bd("R7 write-back entry 5", 5);
    chk_src("R9 RX error source");
    clr_src();
    sc = store_cnt;
    frame(80, 9'h000);
    m_src[4] = 1'b1;
    chk("R8 no store on busy", store_cnt, sc);
    chk_bd("R8 entry unchanged", 4);
    chk_src("R8 busy source");
    clr_src();
    set_bd(4, 32'h0000C000, 32'h3000);
    frame(90, 9'h100);
    m_stat[4] = 32'h005A4100; m_src[6] = 1'b1;
    chk_bd("R6 RX wrap to count", 4);
    chk_src("R9 RX control source");
    clr_src();
    // Disable returns the receive pointer
    set_bd(4, 32'h0000C000, 32'h3000);
    set_bd(5, 32'h0000E000, 32'h4000);
    wr(11'h000, 2);
    sc = store_cnt;
    frame(50, 9'h000);
    chk("R11 disabled ignores frame", store_cnt, sc);
    chk_bd("R11 entry 4 untouched", 4);
    chk_src("R11 no source when disabled");
    wr(11'h000, 3);
    frame(52, 9'h000);
    m_stat[4] = 32'h00344000; m_src[2] = 1'b1;
    chk_bd("R11 pointer back to start", 4);
    chk_bd("R11 entry 5 untouched", 5);
    clr_src();
    @(negedge clk); tx_ctrl_sent = 1'b1;
    @(negedge clk); tx_ctrl_sent = 1'b0;
    m_src[5] = 1'b1;
    chk_src("R9 TX control source");
    repeat (2) @(negedge clk);
    chk("R10 irq on TX control", {31'd0, irq}, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule